// File: doc/BRIEF.md
# VLAN Membership Update Sequencer

This block applies one VLAN membership change to a six-port switch whose configuration lives in 16-bit registers behind a serial register master. A request names a VLAN and gives three 6-bit masks: which ports belong to it, which of those send frames untagged, and which take it as their default VLAN. The block turns the request into an ordered series of register reads and writes on a simple request/acknowledge port that feeds the serial master. It waits for every acknowledge before it moves on.

The series always starts by reading the VLAN's port-map register. It then visits ports 0 to 5 in ascending order. For each member port it reads that port's configuration register and writes back a modified copy. Non-member ports cause no register traffic. The series ends by writing the port map back with the member bits updated. A VLAN number that does not fit in four bits is refused at once, and no register access is made.

Top module: `vlanMapUpdater`

## Requirements
- R1: A request on the register port keeps busReq high, with busAddr, busWrite and busWData unchanged, until busAck is seen high at a clock edge. Each busAck cycle completes exactly one access. For reads, busRdData is taken in that busAck cycle.
- R2: The first access of an update is a read of the port-map register at address 0x13 + n, where n is the VLAN number (0 to 15).
- R3: Only member ports are accessed. Each member port gets a read of its configuration register followed directly by a write to the same address. Ports are handled in ascending order. Ports 0, 1, 2, 3, 4 and 5 use addresses 0x01, 0x03, 0x05, 0x07, 0x08 and 0x09.
- R4: The written configuration value has bit 4 (tag enable) cleared if the port's untagged flag is set, and set otherwise.
- R5: If a port's untagged or default-VLAN flag is set, bits 13:10 of the written configuration value are replaced by the VLAN number. Otherwise they are unchanged. All bits other than 4 and 13:10 are always unchanged.
- R6: The last access is a write to the same port-map address. The map bits for ports 0 to 5 are at positions 0, 2, 4, 6, 7 and 8. Each is set for a member port and cleared for a non-member port. All other bits keep the value that was read.
- R7: busy is high from the cycle after start is accepted until the update ends. done pulses high for one cycle, in the cycle after the final write is acknowledged, and busy is low in that cycle.
- R8: If start is given with vlanIn above 15, err pulses high for one cycle in the next cycle. busy stays low and no register access is made.
- R9: A start while busy is high is ignored. It neither changes the update in progress nor causes a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts an update when idle |
| vlanIn | input | 5 | VLAN number; values above 15 are refused |
| memberMask | input | 6 | Member ports, bit i = port i |
| untagMask | input | 6 | Untagged ports, bit i = port i |
| pvidMask | input | 6 | Ports taking this VLAN as default, bit i = port i |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse when an update ends |
| err | output | 1 | One-cycle pulse when a request is refused |
| busReq | output | 1 | Register access requested |
| busWrite | output | 1 | Access is a write (1) or read (0) |
| busAddr | output | 8 | Register address |
| busWData | output | 16 | Write data |
| busAck | input | 1 | Access completed this cycle |
| busRdData | input | 16 | Read data, valid with busAck on reads |

## Verification
A wrong port index or a lost map capture shows up at the ports as an access at the wrong address, or as a corrupted write value. The bench detects this in the first access after the fault, because it compares every access against a list it computes from the register image it holds. A sequencer that stalls or skips states shows up as a wrong access count, or as a done pulse that is late or missing. Acknowledge latencies from zero to three cycles check that request fields stay stable while an access waits.

// File: rtl/vlanRmwPkg.sv
`timescale 1ns/1ps
package vlanRmwPkg;
  localparam int NUM_PORTS = 6;
  localparam int VLAN_W    = 4;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 16;
  localparam int PORT_W    = $clog2(NUM_PORTS + 1);
  localparam logic [ADDR_W-1:0] MAP_BASE = 8'h13;
  localparam int TAG_BIT   = 4;
  localparam int PVID_LSB  = 10;

  // Per-port configuration address: four odd slots, then consecutive.
  function automatic logic [ADDR_W-1:0] portCfgAddr(input logic [PORT_W-1:0] idx);
    if (idx < 4) portCfgAddr = ADDR_W'(2 * idx + 1);
    else         portCfgAddr = ADDR_W'(idx + 4);
  endfunction

  // Bit position of a port inside the VLAN map register.
  function automatic int portMapBit(input int idx);
    return (idx < 4) ? 2 * idx : idx + 3;
  endfunction

  typedef struct packed {
    logic                capture;
    logic                loadMap;
    logic                loadCfg;
    logic                selPort;
    logic [PORT_W-1:0]   port;
  } ctlStrobe_t;
endpackage

// File: rtl/vlanRmwData.sv
`timescale 1ns/1ps
module vlanRmwData
  import vlanRmwPkg::*;
#(
  parameter int PORTS = NUM_PORTS,
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlStrobe_t       stb,
  input  logic [VLAN_W-1:0] vlanIn,
  input  logic [PORTS-1:0] memberIn,
  input  logic [PORTS-1:0] untagIn,
  input  logic [PORTS-1:0] pvidIn,
  input  logic [DW-1:0]    rdData,
  output logic             isMember,
  output logic [AW-1:0]    reqAddr,
  output logic [DW-1:0]    reqWData
);
  logic [VLAN_W-1:0] vlanQ;
  logic [PORTS-1:0]  memberQ, untagQ, pvidQ;
  logic [DW-1:0]     mapQ, cfgQ, newMap, newCfg, keepMask, setMask;

  always_ff @(posedge clk) begin
    if (rst) begin
      vlanQ <= '0; memberQ <= '0; untagQ <= '0; pvidQ <= '0;
      mapQ <= '0; cfgQ <= '0;
    end else begin
      if (stb.capture) begin
        vlanQ <= vlanIn; memberQ <= memberIn;
        untagQ <= untagIn; pvidQ <= pvidIn;
      end
      if (stb.loadMap) mapQ <= rdData;
      if (stb.loadCfg) cfgQ <= rdData;
    end
  end

  generate
    for (genvar g = 0; g < PORTS; g++) begin : g_mapBit
      localparam int B = portMapBit(g);
      always_comb begin
        keepMask[B] = 1'b0;
        setMask[B]  = memberQ[g];
      end
    end
  endgenerate

  // Positions that do not belong to a port keep the value read back.
  always_comb begin
    for (int b = 0; b < DW; b++) begin
      if (!(b == 0 || b == 2 || b == 4 || b == 6 || b == 7 || b == 8)) begin
        keepMask[b] = 1'b1;
        setMask[b]  = 1'b0;
      end
    end
  end

  assign newMap   = (mapQ & keepMask) | setMask;
  assign isMember = (stb.port < PORTS) ? memberQ[stb.port] : 1'b0;

  always_comb begin
    newCfg = cfgQ;
    if (stb.port < PORTS) begin
      newCfg[TAG_BIT] = ~untagQ[stb.port];
      if (untagQ[stb.port] | pvidQ[stb.port])
        newCfg[PVID_LSB +: VLAN_W] = vlanQ;
    end
  end

  assign reqAddr  = stb.selPort ? portCfgAddr(stb.port) : MAP_BASE + AW'(vlanQ);
  assign reqWData = stb.selPort ? newCfg : newMap;

  a_r2_map_addr_range: assert property (@(posedge clk) disable iff (rst)
    !stb.selPort |-> (reqAddr >= MAP_BASE && reqAddr <= MAP_BASE + 8'd15));
endmodule

// File: rtl/vlanRmwCtrl.sv
`timescale 1ns/1ps
module vlanRmwCtrl
  import vlanRmwPkg::*;
#(
  parameter int PORTS = NUM_PORTS
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        tooBig,
  input  logic        isMember,
  input  logic        busAck,
  output ctlStrobe_t  stb,
  output logic        busReq,
  output logic        busWrite,
  output logic        busy,
  output logic        done,
  output logic        err
);
  typedef enum logic [2:0] {S_IDLE, S_MAP_RD, S_SCAN, S_CFG_RD, S_CFG_WR, S_MAP_WR} state_e;
  state_e stateQ, stateD;
  logic [PORT_W-1:0] portQ, portD;
  logic doneQ, errQ;

  always_comb begin
    stb      = '0;
    stb.port = portQ;
    stateD   = stateQ;
    portD    = portQ;
    case (stateQ)
      S_IDLE: if (start && !tooBig) begin
        stb.capture = 1'b1;
        stateD      = S_MAP_RD;
      end
      S_MAP_RD: if (busAck) begin
        stb.loadMap = 1'b1;
        portD       = '0;
        stateD      = S_SCAN;
      end
      S_SCAN: begin
        if (portQ == PORT_W'(PORTS)) stateD = S_MAP_WR;
        else if (isMember)           stateD = S_CFG_RD;
        else                         portD  = portQ + 1'b1;
      end
      S_CFG_RD: begin
        stb.selPort = 1'b1;
        if (busAck) begin
          stb.loadCfg = 1'b1;
          stateD      = S_CFG_WR;
        end
      end
      S_CFG_WR: begin
        stb.selPort = 1'b1;
        if (busAck) begin
          portD  = portQ + 1'b1;
          stateD = S_SCAN;
        end
      end
      S_MAP_WR: if (busAck) stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= S_IDLE; portQ <= '0; doneQ <= 1'b0; errQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      portQ  <= portD;
      doneQ  <= (stateQ == S_MAP_WR) && busAck;
      errQ   <= (stateQ == S_IDLE) && start && tooBig;
    end
  end

  assign busReq   = (stateQ == S_MAP_RD) || (stateQ == S_CFG_RD) ||
                    (stateQ == S_CFG_WR) || (stateQ == S_MAP_WR);
  assign busWrite = (stateQ == S_CFG_WR) || (stateQ == S_MAP_WR);
  assign busy     = (stateQ != S_IDLE);
  assign done     = doneQ;
  assign err      = errQ;

  a_r3_write_follows_read: assert property (@(posedge clk) disable iff (rst)
    (stateQ == S_CFG_WR) |-> ($past(stateQ) == S_CFG_RD || $past(stateQ) == S_CFG_WR));
  a_r7_done_after_write_ack: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busAck) && $past(busWrite) && !busy));
  a_r8_reject_quiet: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && !busReq));
endmodule

// File: rtl/vlanMapUpdater.sv
`timescale 1ns/1ps
module vlanMapUpdater
  import vlanRmwPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [4:0]  vlanIn,
  input  logic [5:0]  memberMask,
  input  logic [5:0]  untagMask,
  input  logic [5:0]  pvidMask,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        busReq,
  output logic        busWrite,
  output logic [7:0]  busAddr,
  output logic [15:0] busWData,
  input  logic        busAck,
  input  logic [15:0] busRdData
);
  ctlStrobe_t stb;
  logic isMember;
  logic tooBig;

  assign tooBig = (vlanIn > 5'd15);

  vlanRmwCtrl #(.PORTS(NUM_PORTS)) i_ctrl (
    .clk(clk), .rst(rst), .start(start), .tooBig(tooBig), .isMember(isMember),
    .busAck(busAck), .stb(stb), .busReq(busReq), .busWrite(busWrite),
    .busy(busy), .done(done), .err(err)
  );

  vlanRmwData #(.PORTS(NUM_PORTS), .DW(DATA_W), .AW(ADDR_W)) i_data (
    .clk(clk), .rst(rst), .stb(stb), .vlanIn(vlanIn[VLAN_W-1:0]),
    .memberIn(memberMask), .untagIn(untagMask), .pvidIn(pvidMask),
    .rdData(busRdData), .isMember(isMember), .reqAddr(busAddr), .reqWData(busWData)
  );

  a_r1_req_held: assert property (@(posedge clk) disable iff (rst)
    (busReq && !busAck) |=> (busReq && $stable(busAddr) && $stable(busWrite) && $stable(busWData)));
endmodule

// File: tb/test_vlanMapUpdater.sv
`timescale 1ns/1ps
module test_vlanMapUpdater;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [4:0] vlanIn = '0;
  logic [5:0] memberMask = '0, untagMask = '0, pvidMask = '0;
  logic busy, done, err, busReq, busWrite, busAck = 1'b0;
  logic [7:0] busAddr;
  logic [15:0] busWData, busRdData = '0;

  int checks = 0, fails = 0, lat = 0, waitCnt = 0, cycles = 0;
  logic [15:0] mem [0:255];
  int logN = 0;
  logic logWr [0:31];
  logic [7:0] logAddr [0:31];
  logic [15:0] logData [0:31];
  int expN;
  logic expWr [0:31];
  logic [7:0] expAddr [0:31];
  logic [15:0] expData [0:31];

  always #2 clk = ~clk;

  vlanMapUpdater i_vlanMapUpdater (
    .clk(clk), .rst(rst), .start(start), .vlanIn(vlanIn), .memberMask(memberMask),
    .untagMask(untagMask), .pvidMask(pvidMask), .busy(busy), .done(done), .err(err),
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr), .busWData(busWData),
    .busAck(busAck), .busRdData(busRdData));

  // Register master model with programmable latency.
  always @(negedge clk) begin
    cycles++;
    if (busAck) busAck = 1'b0;
    else if (busReq && !rst) begin
      if (waitCnt >= lat) begin
        waitCnt = 0;
        if (logN < 32) begin
          logWr[logN] = busWrite; logAddr[logN] = busAddr; logData[logN] = busWData;
        end
        logN++;
        if (busWrite) mem[busAddr] = busWData;
        else busRdData = mem[busAddr];
        busAck = 1'b1;
      end else waitCnt++;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cfgAddrOf(input int i);
    case (i) 0: return 8'h01; 1: return 8'h03; 2: return 8'h05;
             3: return 8'h07; 4: return 8'h08; default: return 8'h09; endcase
  endfunction
  function automatic int mapBitOf(input int i);
    case (i) 0: return 0; 1: return 2; 2: return 4; 3: return 6; 4: return 7; default: return 8; endcase
  endfunction

  task automatic buildExp(input int n, input logic [5:0] m, input logic [5:0] u, input logic [5:0] p);
    logic [15:0] v, mp;
    expN = 0;
    expWr[0] = 0; expAddr[0] = 8'h13 + 8'(n); expData[0] = 'x; expN = 1;
    for (int i = 0; i < 6; i++) if (m[i]) begin
      v = mem[cfgAddrOf(i)];
      v[4] = ~u[i];
      if (u[i] | p[i]) v[13:10] = 4'(n);
      expWr[expN] = 0; expAddr[expN] = cfgAddrOf(i); expN++;
      expWr[expN] = 1; expAddr[expN] = cfgAddrOf(i); expData[expN] = v; expN++;
    end
    mp = mem[8'h13 + 8'(n)];
    for (int i = 0; i < 6; i++) mp[mapBitOf(i)] = m[i];
    expWr[expN] = 1; expAddr[expN] = 8'h13 + 8'(n); expData[expN] = mp; expN++;
  endtask

  task automatic pulseStart(input int n, input logic [5:0] m, input logic [5:0] u, input logic [5:0] p);
    @(negedge clk);
    vlanIn = 5'(n); memberMask = m; untagMask = u; pvidMask = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitEnd(output logic gotDone);
    gotDone = 0;
    for (int k = 0; k < 400; k++) begin
      if (done) begin gotDone = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic compareLog(input string tag);
    check(logN == expN, {tag, " access count"}, logN, expN);
    for (int k = 0; k < expN && k < logN; k++) begin
      check(logWr[k] == expWr[k], {tag, " direction"}, logWr[k], expWr[k]);
      check(logAddr[k] == expAddr[k], {tag, " address"}, logAddr[k], expAddr[k]);
      if (expWr[k]) check(logData[k] == expData[k], {tag, " write data"}, logData[k], expData[k]);
    end
  endtask

  task automatic runUpdate(input string tag, input int n, input logic [5:0] m,
                           input logic [5:0] u, input logic [5:0] p, input int latency);
    logic gd;
    lat = latency; logN = 0;
    buildExp(n, m, u, p);
    pulseStart(n, m, u, p);
    check(busy == 1'b1, "R7 busy after start", busy, 1);
    waitEnd(gd);
    check(gd, "R7 done pulse seen", gd, 1);
    check(busy == 1'b0, "R7 busy low with done", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", done, 0);
    compareLog(tag);
  endtask

  task automatic testReset();
    check(busy == 0 && done == 0 && err == 0 && busReq == 0, "reset idle",
          {busy, done, err, busReq}, 0);
  endtask

  task automatic testReject(input int n);
    logN = 0;
    pulseStart(n, 6'h3f, 6'h3f, 6'h3f);
    check(err == 1'b1, "R8 err pulse", err, 1);
    check(busy == 1'b0, "R8 stays idle", busy, 0);
    @(negedge clk);
    check(err == 1'b0, "R8 err one cycle", err, 0);
    repeat (10) @(negedge clk);
    check(logN == 0, "R8 no register access", logN, 0);
  endtask

  task automatic testIgnoreWhileBusy();
    logic gd;
    lat = 2; logN = 0;
    buildExp(2, 6'b011010, 6'b000010, 6'b010000);
    pulseStart(2, 6'b011010, 6'b000010, 6'b010000);
    repeat (3) @(negedge clk);
    vlanIn = 5'd5; memberMask = 6'h3f; untagMask = 6'h3f; pvidMask = 6'h00; start = 1'b1;
    @(negedge clk); start = 1'b0;
    waitEnd(gd);
    check(gd, "R9 first update completes", gd, 1);
    @(negedge clk);
    compareLog("R9");
    repeat (30) @(negedge clk);
    check(logN == expN, "R9 no second update", logN, expN);
    check(busy == 1'b0, "R9 idle afterwards", busy, 0);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 16'(a * 16'h1357) ^ 16'h5aa5;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    runUpdate("R2 R3 R4 R5 R6 basic", 3, 6'b000101, 6'b000001, 6'b000100, 1);
    runUpdate("R1 R4 R5 all members vlan15", 15, 6'b111111, 6'b000000, 6'b111111, 0);
    runUpdate("R6 no members vlan0", 0, 6'b000000, 6'b000000, 6'b000000, 2);
    runUpdate("R1 R3 upper ports vlan9", 9, 6'b110010, 6'b100000, 6'b000000, 3);
    runUpdate("R5 plain tagged member", 7, 6'b001000, 6'b000000, 6'b000000, 1);
    testReject(16);
    testReject(31);
    testIgnoreWhileBusy();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    fails++;
    $display("FAIL watchdog actual=0x%0h expected=0x0", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule